// File: doc/BRIEF.md
# Return-to-Zero One-Bit FIR DAC Tap Generator

This block takes the one-bit output of a modulator and produces the registered tap bits that drive the resistor array of a balanced semi-digital FIR DAC. A single shift clock drives every register in the block, and that clock runs at twice the bit rate. A phase toggle splits the shift clock into alternating data and zero slots. In a return-to-zero mode, the encoder places the sampled bit and its complement on the two balanced lines during the data slot. During the zero slot it drives both lines low. A retiming register takes the encoded pair before it enters two tap sections of `NTAP` stages each.

A three-bit mode input sets how the second section is fed. It can be a polarity-swapped copy of the first section (double balanced). It can be the continuation of the first section (one long FIR). It can be a copy of the first section delayed by one shift clock (interleaved). Non-return-to-zero operation does not use a second clock. Instead, shifting is enabled only in the data slot, so adjacent taps sit one full bit apart and no zero slot is inserted.

Top module: `fdac_tapgen`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `tap_p` and `tap_n` is 0 after that edge, and the next rising edge after release is a data slot.
- R2: In return-to-zero modes, tap pair 0 shows (bit, not bit) after every even edge counted from release and (0,0) after every odd edge. No tap ever has both lines at 1.
- R3: In return-to-zero modes, every section shifts on every edge: tap k equals tap k-1 from the previous cycle.
- R4: In non-return-to-zero modes (codes 1 and 3), no tap changes on zero-slot edges. On data edges, tap pair 0 takes (bit, not bit) of the bit sampled two edges earlier.
- R5: In double-balanced modes (codes 0 and 1), every tap of the second section carries the matching first-section tap with p and n swapped.
- R6: In series modes (codes 2 and 3), the first tap of the second section takes the last tap of the first section whenever the block shifts, forming one 2*NTAP-tap chain.
- R7: In interleaved mode (code 4), every tap of the second section equals the same tap of the first section one shift clock earlier.
- R8: Codes 5, 6 and 7 behave exactly as code 0.
- R9: `bit_in` is sampled only on data-slot edges. A new `mode_code` takes effect from the next data-slot edge, and the zero slot before that edge still follows the old mode.
- R10: With a fixed input bit of 1, the differential level is constant once the taps are filled. The level is the sum over first-section taps of (p-n), plus the same sum over second-section taps, with the second-section sum negated in codes 0 and 1. For NTAP=4 it equals 4 in codes 0, 2, 4 and 6, and 8 in codes 1 and 3. With a fixed input bit of 0 the level is the negative of these values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| mode_code | input | 3 | Section arrangement and encoding select |
| bit_in | input | 1 | One-bit modulator stream |
| tap_p | output | 2*NTAP | Positive-line tap bits; [NTAP-1:0] first section, upper half second section |
| tap_n | output | 2*NTAP | Negative-line tap bits, same ordering |

## Verification
The bench builds the block with the default NTAP of 4, giving an eight-tap series chain and a complete fill within about twenty shift clocks. At that size, a random bit stream can be checked edge by edge in every mode, including the zero-slot samples that must ignore `bit_in`. Steady runs at each fixed bit reach the full differential level of every arrangement. A mode switch placed just before a zero slot shows that the switch waits for the next data slot.

// File: rtl/fdac_pkg.sv
package fdac_pkg;

    typedef enum logic [2:0] {
        M_DB_RTZ  = 3'd0,
        M_DB_NRZ  = 3'd1,
        M_SER_RTZ = 3'd2,
        M_SER_NRZ = 3'd3,
        M_ILV_RTZ = 3'd4
    } mode_e;

    typedef struct packed {
        logic p;
        logic n;
    } line_pair_t;

    function automatic mode_e decode_mode(input logic [2:0] code);
        mode_e m;
        case (code)
            3'd1:    m = M_DB_NRZ;
            3'd2:    m = M_SER_RTZ;
            3'd3:    m = M_SER_NRZ;
            3'd4:    m = M_ILV_RTZ;
            default: m = M_DB_RTZ;
        endcase
        return m;
    endfunction

    function automatic logic is_rtz(input mode_e m);
        return (m == M_DB_RTZ) || (m == M_SER_RTZ) || (m == M_ILV_RTZ);
    endfunction

    function automatic logic is_dual(input mode_e m);
        return (m == M_DB_RTZ) || (m == M_DB_NRZ);
    endfunction

    function automatic logic is_series(input mode_e m);
        return (m == M_SER_RTZ) || (m == M_SER_NRZ);
    endfunction

    function automatic line_pair_t swap_pair(input line_pair_t x);
        line_pair_t y;
        y.p = x.n;
        y.n = x.p;
        return y;
    endfunction

endpackage

// File: rtl/fdac_encoder.sv
module fdac_encoder
    import fdac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_code,
    input  logic       bit_in,
    output line_pair_t ret_q,
    output logic       shift_en,
    output mode_e      mode_eff
);

    logic  zslot_q;   // 0: data slot, 1: zero slot
    mode_e mode_q;
    logic  rtz;

    assign mode_eff = zslot_q ? mode_q : decode_mode(mode_code);
    assign rtz      = is_rtz(mode_eff);
    assign shift_en = rtz || !zslot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            zslot_q <= 1'b0;
            mode_q  <= M_DB_RTZ;
            ret_q   <= '0;
        end else begin
            zslot_q <= !zslot_q;
            if (!zslot_q) begin
                mode_q  <= mode_eff;
                ret_q.p <= bit_in;
                ret_q.n <= !bit_in;
            end else if (rtz) begin
                ret_q <= '0;
            end
        end
    end

    // R8: a code outside the defined set latches as double-balanced RTZ
    p_unused_code_r8: assert property (@(posedge clk) disable iff (rst)
        (!zslot_q && mode_code > 3'd4) |=> (mode_q == M_DB_RTZ));

    // R2: the retimed pair is never both high
    p_ret_legal_r2: assert property (@(posedge clk) disable iff (rst)
        !(ret_q.p && ret_q.n));

endmodule

// File: rtl/fdac_chain.sv
module fdac_chain
    import fdac_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  line_pair_t             din,
    output line_pair_t [DEPTH-1:0] taps
);

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (en) begin
            taps[0] <= din;
            for (int k = 1; k < DEPTH; k++) begin
                taps[k] <= taps[k-1];
            end
        end
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(taps));

    generate
        if (DEPTH > 1) begin : g_shift_chk
            p_shift_r3: assert property (@(posedge clk) disable iff (rst)
                en |=> (taps[1] == $past(taps[0])));
        end
        for (genvar k = 0; k < DEPTH; k++) begin : g_legal
            p_never_both_r2: assert property (@(posedge clk) disable iff (rst)
                !(taps[k].p && taps[k].n));
        end
    endgenerate

endmodule

// File: rtl/fdac_tapgen.sv
module fdac_tapgen
    import fdac_pkg::*;
#(
    parameter int NTAP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_code,
    input  logic              bit_in,
    output logic [2*NTAP-1:0] tap_p,
    output logic [2*NTAP-1:0] tap_n
);

    localparam int NOUT = 2 * NTAP;

    line_pair_t             ret_q;
    logic                   shift_en;
    mode_e                  mode_eff;
    line_pair_t [NTAP-1:0]  sec_a;
    line_pair_t [NTAP-1:0]  sec_b;
    line_pair_t             b_feed;

    fdac_encoder u_enc (
        .clk       (clk),
        .rst       (rst),
        .mode_code (mode_code),
        .bit_in    (bit_in),
        .ret_q     (ret_q),
        .shift_en  (shift_en),
        .mode_eff  (mode_eff)
    );

    fdac_chain #(.DEPTH(NTAP)) u_sec_a (
        .clk  (clk),
        .rst  (rst),
        .en   (shift_en),
        .din  (ret_q),
        .taps (sec_a)
    );

    always_comb begin
        if (is_dual(mode_eff)) begin
            b_feed = swap_pair(ret_q);
        end else if (is_series(mode_eff)) begin
            b_feed = sec_a[NTAP-1];
        end else begin
            b_feed = sec_a[0];
        end
    end

    fdac_chain #(.DEPTH(NTAP)) u_sec_b (
        .clk  (clk),
        .rst  (rst),
        .en   (shift_en),
        .din  (b_feed),
        .taps (sec_b)
    );

    generate
        for (genvar k = 0; k < NTAP; k++) begin : g_out
            assign tap_p[k]      = sec_a[k].p;
            assign tap_n[k]      = sec_a[k].n;
            assign tap_p[NTAP+k] = sec_b[k].p;
            assign tap_n[NTAP+k] = sec_b[k].n;
        end
    endgenerate

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (tap_p == {NOUT{1'b0}} && tap_n == {NOUT{1'b0}}));

    p_dual_swap_r5: assert property (@(posedge clk) disable iff (rst)
        is_dual(mode_eff) |=> (sec_b[0] == swap_pair(sec_a[0])));

    p_series_link_r6: assert property (@(posedge clk) disable iff (rst)
        (is_series(mode_eff) && shift_en) |=> (sec_b[0] == $past(sec_a[NTAP-1])));

    p_interleave_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == M_ILV_RTZ) |=> (sec_b[0] == $past(sec_a[0])));

endmodule

// File: tb/fdac_tapgen_bench.sv
module fdac_tapgen_bench;

    localparam int NTAP = 4;
    localparam int NOUT = 2 * NTAP;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      mode = 3'd0;
    logic            bit_in = 1'b0;
    logic [NOUT-1:0] tap_p;
    logic [NOUT-1:0] tap_n;

    int   n_chk = 0;
    int   n_bad = 0;
    int   e = 0;
    logic bit_at [0:255];

    always #10 clk = ~clk;

    fdac_tapgen #(.NTAP(NTAP)) u_fdac_tapgen (
        .clk       (clk),
        .rst       (rst),
        .mode_code (mode),
        .bit_in    (bit_in),
        .tap_p     (tap_p),
        .tap_n     (tap_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        e++;
    endtask

    function automatic int pr(input logic [NOUT-1:0] p, input logic [NOUT-1:0] n, input int i);
        return {30'd0, p[i], n[i]};
    endfunction

    function automatic int level(input logic [2:0] m);
        int sa = 0;
        int sb = 0;
        for (int k = 0; k < NTAP; k++) begin
            sa += int'(tap_p[k]) - int'(tap_n[k]);
            sb += int'(tap_p[NTAP+k]) - int'(tap_n[NTAP+k]);
        end
        if (m <= 3'd1 || m >= 3'd5) return sa - sb;
        return sa + sb;
    endfunction

    task automatic do_reset(input logic [2:0] m, input logic b);
        rst = 1'b1;
        mode = m;
        bit_in = b;
        step();
        step();
        check("R1", "tap_p after reset", int'(tap_p), 0);
        check("R1", "tap_n after reset", int'(tap_n), 0);
        rst = 1'b0;
        e = 0;
    endtask

    // Random stream, edge-by-edge relations for one mode
    task automatic run_pattern(input logic [2:0] m);
        logic [NOUT-1:0] pp;
        logic [NOUT-1:0] pn;
        bit nrz;
        bit dual;
        nrz  = (m == 3'd1) || (m == 3'd3);
        dual = (m <= 3'd1) || (m >= 3'd5);
        do_reset(m, 1'b0);
        for (int t = 0; t < 60; t++) begin
            pp = tap_p;
            pn = tap_n;
            bit_in = 1'($urandom % 2);
            bit_at[e+1] = bit_in;
            step();
            if (!nrz) begin
                if (e % 2 == 1)
                    check("R2", "zero slot tap0", pr(tap_p, tap_n, 0), 0);
                else
                    check("R9", "data tap0 uses data-slot bit", pr(tap_p, tap_n, 0),
                          bit_at[e-1] ? 2 : 1);
                for (int k = 1; k < NTAP; k++)
                    check("R3", "section A shift", pr(tap_p, tap_n, k), pr(pp, pn, k-1));
                if (m == 3'd2) begin
                    check("R6", "series link", pr(tap_p, tap_n, NTAP), pr(pp, pn, NTAP-1));
                    for (int k = 1; k < NTAP; k++)
                        check("R6", "section B shift", pr(tap_p, tap_n, NTAP+k), pr(pp, pn, NTAP+k-1));
                end
                if (m == 3'd4) begin
                    for (int k = 0; k < NTAP; k++)
                        check("R7", "interleaved copy", pr(tap_p, tap_n, NTAP+k), pr(pp, pn, k));
                end
            end else begin
                if (e % 2 == 0) begin
                    check("R4", "hold tap_p in zero slot", int'(tap_p), int'(pp));
                    check("R4", "hold tap_n in zero slot", int'(tap_n), int'(pn));
                end else if (e >= 3) begin
                    check("R4", "nrz tap0", pr(tap_p, tap_n, 0), bit_at[e-2] ? 2 : 1);
                    for (int k = 1; k < NTAP; k++)
                        check("R4", "nrz shift", pr(tap_p, tap_n, k), pr(pp, pn, k-1));
                    if (m == 3'd3)
                        check("R6", "series nrz link", pr(tap_p, tap_n, NTAP), pr(pp, pn, NTAP-1));
                end
            end
            if (dual) begin
                for (int k = 0; k < NTAP; k++)
                    check(m >= 3'd5 ? "R8" : "R5", "swapped section B",
                          pr(tap_p, tap_n, NTAP+k), {30'd0, tap_n[k], tap_p[k]});
            end
        end
    endtask

    task automatic run_steady(input logic [2:0] m, input logic b, input int expv);
        int acc = 0;
        do_reset(m, b);
        repeat (30) step();
        for (int t = 0; t < 32; t++) begin
            step();
            acc += level(m);
            check("R10", $sformatf("level mode %0d bit %0d", m, b), level(m), expv);
        end
        check("R10", "average level x32", acc, expv * 32);
    endtask

    task automatic run_mode_change();
        logic [NOUT-1:0] pp;
        logic [NOUT-1:0] pn;
        do_reset(3'd0, 1'b1);
        repeat (11) step();
        pp = tap_p;
        pn = tap_n;
        mode = 3'd1;
        step(); // zero-slot edge, old mode still active
        check("R9", "zero slot keeps old mode shift", pr(tap_p, tap_n, 1), pr(pp, pn, 0));
        check("R9", "tap1 is return-to-zero", pr(tap_p, tap_n, 1), 0);
        step(); // data edge, new mode
        check("R9", "last rtz zero reaches tap0", pr(tap_p, tap_n, 0), 0);
        pp = tap_p;
        pn = tap_n;
        step(); // zero slot, now non-return-to-zero: hold
        check("R9", "new mode holds tap_p", int'(tap_p), int'(pp));
        check("R9", "new mode holds tap_n", int'(tap_n), int'(pn));
        step();
        check("R9", "new mode data on tap0", pr(tap_p, tap_n, 0), 2);
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        run_pattern(3'd0);
        run_pattern(3'd1);
        run_pattern(3'd2);
        run_pattern(3'd3);
        run_pattern(3'd4);
        run_pattern(3'd5);
        run_pattern(3'd7);
        run_steady(3'd0, 1'b1, 4);
        run_steady(3'd1, 1'b1, 8);
        run_steady(3'd2, 1'b1, 4);
        run_steady(3'd3, 1'b1, 8);
        run_steady(3'd4, 1'b1, 4);
        run_steady(3'd6, 1'b1, 4);
        run_steady(3'd0, 1'b0, -4);
        run_steady(3'd3, 1'b0, -8);
        run_steady(3'd4, 1'b0, -4);
        run_mode_change();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule